// File: doc/BRIEF.md
# Configurable Parallel CRC Generator and Checker

This block computes a cyclic redundancy check over a message that arrives one data word per clock. Every accepted word is folded into a running check register in one cycle, the word being the dividend and a generator polynomial fixed at build time the divisor, in modulo-2 arithmetic. A start flag marks the first word of a message and an end flag marks the last. One cycle after the last word is accepted, the conditioned remainder appears on the result port with a done flag. Both hold until the next message starts.

Build-time options apply to both sides of the division. On the input side, each byte can be bit-reversed or inverted before it enters the division. On the output side, the remainder can be bit-reversed or inverted. Together with a parameterized initial register value, these options cover the common reflected and unreflected CRC variants from 1 to 64 bits.

A mode input selects the role of the block. As a generator it only produces the check value. As a checker it also compares its own result with a received check value presented alongside the final word, and raises an error flag when the two differ.

Top module: `crc_engine`

## Requirements
- R1: With no conditioning options, the result equals the remainder of the message bits (word MSB first) with the register preset to INIT, shifted through the generator POLY whose top term is implicit. The default CRC-16 with POLY 0x8005 and INIT 0 gives 0xFEE8 for the ASCII bytes "123456789".
- R2: An accepted word flagged as start of message is folded into INIT instead of into the previous register value. A start flag without valid loads INIT.
- R3: While valid is low the check register keeps its value, so idle cycles inserted between words leave the result unchanged.
- R4: With IN_REV set, the bit order of each input byte is reversed before division, so byte bit 0 is divided first.
- R5: With IN_INV set, every input bit is inverted before division.
- R6: With OUT_REV set, the result is the remainder with its CRC_W bits reversed end to end.
- R7: With OUT_INV set, every result bit is inverted. CRC_W=32, POLY 0x04C11DB7, INIT all ones, IN_REV, OUT_REV and OUT_INV together give 0xCBF43926 for "123456789".
- R8: crc_done is low after reset. It rises on the clock edge that accepts an end-of-message word, when crc_out is updated at the same edge. The result and crc_done hold until a start word that is not also an end word is accepted, which clears crc_done.
- R9: In checker mode (chk_en=1 at the end word), crc_err is 1 if rx_crc differs from the conditioned result and 0 if it matches.
- R10: In generator mode (chk_en=0 at the end word), crc_err is 0 whatever rx_crc holds.
- R11: A word wider than one byte is divided byte by byte, starting with its most significant byte, and each byte is conditioned on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A data word is presented this cycle |
| in_sop | input | 1 | First word of a message; restarts from INIT |
| in_eop | input | 1 | Last word of a message |
| in_data | input | DATA_W | Message word, MSB byte first |
| chk_en | input | 1 | 1 = checker mode, 0 = generator mode |
| rx_crc | input | CRC_W | Received check value, sampled with the end word |
| crc_out | output | CRC_W | Conditioned remainder of the last message |
| crc_done | output | 1 | crc_out holds the result of a completed message |
| crc_err | output | 1 | Checker mismatch for the last message |

## Verification
The bench drives three instances from one stimulus stream. The first uses the defaults, an 8-bit word with an unreflected 16-bit polynomial. The second uses an 8-bit word with the reflected, preset and inverted 32-bit form, and so exercises input and output reversal, output inversion and a nonzero preset. The third uses a 16-bit word with an 8-bit polynomial and input inversion, which covers multi-byte words and a check value narrower than the word. Known check values for "123456789" tie the first two instances to published results, and a bit-serial reference model covers random messages with idle gaps and with both modes.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;

  localparam int BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] byte_mirror(input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] m;
    for (int i = 0; i < BYTE_W; i++) m[i] = b[BYTE_W-1-i];
    return m;
  endfunction

endpackage

// File: rtl/crc_in_cond.sv
module crc_in_cond #(
  parameter int DATA_W = 8,
  parameter bit IN_REV = 1'b0,
  parameter bit IN_INV = 1'b0
) (
  input  logic [DATA_W-1:0] raw_word,
  output logic [DATA_W-1:0] cond_word
);
  import crc_pkg::*;

  localparam int NBYTES = DATA_W / BYTE_W;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_raw;
    logic [BYTE_W-1:0] lane_inv;
    assign lane_raw = raw_word[g*BYTE_W +: BYTE_W];
    if (IN_INV) begin : g_inv
      assign lane_inv = ~lane_raw;
    end else begin : g_pass
      assign lane_inv = lane_raw;
    end
    if (IN_REV) begin : g_rev
      assign cond_word[g*BYTE_W +: BYTE_W] = byte_mirror(lane_inv);
    end else begin : g_keep
      assign cond_word[g*BYTE_W +: BYTE_W] = lane_inv;
    end
  end

endmodule

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
  parameter int          DATA_W = 8,
  parameter int          CRC_W  = 16,
  parameter logic [63:0] POLY   = 64'h8005,
  parameter logic [63:0] INIT   = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] word,
  output logic [CRC_W-1:0]  crc_q,
  output logic [CRC_W-1:0]  crc_next
);

  localparam logic [CRC_W-1:0] GEN  = POLY[CRC_W-1:0];
  localparam logic [CRC_W-1:0] SEED = INIT[CRC_W-1:0];

  // Unrolled bit-serial division, most significant data bit first.
  function automatic logic [CRC_W-1:0] fold_word(input logic [CRC_W-1:0] c,
                                                 input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic             fb;
    r = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r  = r << 1;
      if (fb) r = r ^ GEN;
    end
    return r;
  endfunction

  logic [CRC_W-1:0] base_val;
  logic [CRC_W-1:0] crc_d;

  assign base_val = load ? SEED : crc_q;
  assign crc_next = fold_word(base_val, word);
  assign crc_d    = step ? crc_next : base_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_d;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(crc_q)); // R3

  AST_START_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !step) |=> (crc_q == SEED)); // R2

endmodule

// File: rtl/crc_out_cond.sv
module crc_out_cond #(
  parameter int CRC_W   = 16,
  parameter bit OUT_REV = 1'b0,
  parameter bit OUT_INV = 1'b0
) (
  input  logic [CRC_W-1:0] rem_in,
  output logic [CRC_W-1:0] rem_out
);

  logic [CRC_W-1:0] mirrored;

  if (OUT_REV) begin : g_rev
    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
      assign mirrored[i] = rem_in[CRC_W-1-i];
    end
  end else begin : g_keep
    assign mirrored = rem_in;
  end

  if (OUT_INV) begin : g_inv
    assign rem_out = ~mirrored;
  end else begin : g_pass
    assign rem_out = mirrored;
  end

endmodule

// File: rtl/crc_result.sv
module crc_result #(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_fire,
  input  logic             start_fire,
  input  crc_pkg::crc_mode_e mode,
  input  logic [CRC_W-1:0] final_val,
  input  logic [CRC_W-1:0] rx_val,
  output logic [CRC_W-1:0] res_q,
  output logic             done_q,
  output logic             err_q
);
  import crc_pkg::*;

  logic mismatch;
  assign mismatch = (final_val != rx_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (end_fire) begin
      res_q  <= final_val;
      done_q <= 1'b1;
      err_q  <= (mode == MODE_CHK) && mismatch;
    end else if (start_fire) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end
  end

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |=> done_q); // R8

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_fire && !end_fire) |=> !done_q); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !end_fire |=> $stable(res_q)); // R8

  AST_GEN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && mode == MODE_GEN) |=> !err_q); // R10

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> done_q); // R9

endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int          DATA_W  = 8,
  parameter int          CRC_W   = 16,
  parameter logic [63:0] POLY    = 64'h8005,
  parameter logic [63:0] INIT    = 64'h0,
  parameter bit          IN_REV  = 1'b0,
  parameter bit          IN_INV  = 1'b0,
  parameter bit          OUT_REV = 1'b0,
  parameter bit          OUT_INV = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              chk_en,
  input  logic [CRC_W-1:0]  rx_crc,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done,
  output logic              crc_err
);
  import crc_pkg::*;

  // Named internal events for the assertions.
  logic               word_take;
  logic               start_fire;
  logic               end_fire;
  logic [DATA_W-1:0]  cond_word;
  logic [CRC_W-1:0]   crc_q;
  logic [CRC_W-1:0]   crc_next;
  logic [CRC_W-1:0]   final_val;
  crc_mode_e          mode;

  assign word_take  = in_valid;
  assign start_fire = in_valid && in_sop;
  assign end_fire   = in_valid && in_eop;
  assign mode       = chk_en ? MODE_CHK : MODE_GEN;

  crc_in_cond #(
    .DATA_W (DATA_W),
    .IN_REV (IN_REV),
    .IN_INV (IN_INV)
  ) u_in (
    .raw_word  (in_data),
    .cond_word (cond_word)
  );

  crc_lfsr #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .INIT   (INIT)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_sop),
    .step     (word_take),
    .word     (cond_word),
    .crc_q    (crc_q),
    .crc_next (crc_next)
  );

  crc_out_cond #(
    .CRC_W   (CRC_W),
    .OUT_REV (OUT_REV),
    .OUT_INV (OUT_INV)
  ) u_out (
    .rem_in  (crc_next),
    .rem_out (final_val)
  );

  crc_result #(
    .CRC_W (CRC_W)
  ) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .end_fire   (end_fire),
    .start_fire (start_fire),
    .mode       (mode),
    .final_val  (final_val),
    .rx_val     (rx_crc),
    .res_q      (crc_out),
    .done_q     (crc_done),
    .err_q      (crc_err)
  );

  initial begin
    AST_PARAM_SANE: assert (DATA_W % 8 == 0 && CRC_W >= 1 && CRC_W <= 64); // R11
  end

  AST_CHK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && chk_en && rx_crc == final_val) |=> !crc_err); // R9

  AST_CHK_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (end_fire && chk_en && rx_crc != final_val) |=> crc_err); // R9

endmodule

// File: tb/crc_engine_test.sv
`timescale 1ns/1ps
module crc_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0, sop = 1'b0, eop = 1'b0, chk = 1'b0;
  logic [15:0] d16 = '0;
  logic [15:0] rx_a = '0;
  logic [31:0] rx_b = '0;
  logic [7:0]  rx_c = '0;
  logic [15:0] out_a;
  logic [31:0] out_b;
  logic [7:0]  out_c;
  logic        done_a, done_b, done_c, err_a, err_b, err_c;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  crc_engine uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_sop(sop), .in_eop(eop),
    .in_data(d16[7:0]), .chk_en(chk), .rx_crc(rx_a),
    .crc_out(out_a), .crc_done(done_a), .crc_err(err_a));

  crc_engine #(.DATA_W(8), .CRC_W(32), .POLY(64'h04C11DB7), .INIT(64'hFFFFFFFF),
               .IN_REV(1'b1), .OUT_REV(1'b1), .OUT_INV(1'b1)) uut_refl (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_sop(sop), .in_eop(eop),
    .in_data(d16[7:0]), .chk_en(chk), .rx_crc(rx_b),
    .crc_out(out_b), .crc_done(done_b), .crc_err(err_b));

  crc_engine #(.DATA_W(16), .CRC_W(8), .POLY(64'h07), .IN_INV(1'b1)) uut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(v), .in_sop(sop), .in_eop(eop),
    .in_data(d16), .chk_en(chk), .rx_crc(rx_c),
    .crc_out(out_c), .crc_done(done_c), .crc_err(err_c));

  typedef struct {
    string       req;
    logic [15:0] ea;
    logic [31:0] eb;
    logic [7:0]  ec;
    logic        er;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bit-serial reference: each byte conditioned, MSB byte of a word first.
  function automatic logic [63:0] model(input int dw, input int cw, input logic [63:0] poly,
      input logic [63:0] init, input bit irev, input bit iinv, input bit orev, input bit oinv,
      input logic [15:0] w[$]);
    logic [63:0] mask;
    logic [63:0] r;
    logic [63:0] o;
    logic [7:0]  b;
    logic        fb;
    mask = (cw == 64) ? '1 : ((64'd1 << cw) - 64'd1);
    r = init & mask;
    foreach (w[k]) begin
      for (int bi = dw/8 - 1; bi >= 0; bi--) begin
        b = w[k][bi*8 +: 8];
        if (iinv) b = ~b;
        if (irev) b = {<<{b}};
        for (int j = 7; j >= 0; j--) begin
          fb = r[cw-1] ^ b[j];
          r = (r << 1) & mask;
          if (fb) r = r ^ (poly & mask);
        end
      end
    end
    o = r;
    if (orev) begin
      o = '0;
      for (int j = 0; j < cw; j++) o[cw-1-j] = r[j];
    end
    if (oinv) o = ~o & mask;
    return o;
  endfunction

  // Driver: pushes expectations, then sends the words.
  task automatic send(input string req, input logic [15:0] w[$], input int gap,
                      input bit mode, input bit corrupt);
    exp_t e;
    e.req = req;
    e.ea = model(8, 16, 64'h8005, 64'h0, 0, 0, 0, 0, w)[15:0];
    e.eb = model(8, 32, 64'h04C11DB7, 64'hFFFFFFFF, 1, 0, 1, 1, w)[31:0];
    e.ec = model(16, 8, 64'h07, 64'h0, 0, 1, 0, 0, w)[7:0];
    e.er = mode && corrupt;
    sb.push_back(e);
    foreach (w[k]) begin
      @(negedge clk);
      v = 1'b1; sop = (k == 0); eop = (k == w.size() - 1); d16 = w[k]; chk = mode;
      rx_a = corrupt ? e.ea ^ 16'h1 : e.ea;
      rx_b = corrupt ? e.eb ^ 32'h80 : e.eb;
      rx_c = corrupt ? e.ec ^ 8'h4 : e.ec;
      if (k == 0 && w.size() > 1) begin
        @(negedge clk);
        v = 1'b0; sop = 1'b0;
        check("R8 done cleared by start", {61'd0, done_a, done_b, done_c}, 64'd0);
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        v = 1'b0; sop = 1'b0; eop = 1'b0; d16 = 16'hDEAD ^ 16'(g);
      end
    end
    @(negedge clk);
    v = 1'b0; sop = 1'b0; eop = 1'b0;
  endtask

  // Monitor: the result appears at the edge that accepts the end word.
  logic eop_seen = 1'b0;
  always @(posedge clk) eop_seen <= v && eop;

  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (eop_seen) begin
        if (sb.size() == 0) check("R8 unexpected result", 64'd1, 64'd0);
        else begin
          e = sb.pop_front();
          check({e.req, " R8 done"}, {61'd0, done_a, done_b, done_c}, 64'd7);
          check({e.req, " R1 crc16"}, {48'd0, out_a}, {48'd0, e.ea});
          check({e.req, " R4 R6 R7 crc32"}, {32'd0, out_b}, {32'd0, e.eb});
          check({e.req, " R5 R11 crc8 wide"}, {56'd0, out_c}, {56'd0, e.ec});
          check({e.req, " R9 R10 err"}, {61'd0, err_a, err_b, err_c},
                e.er ? 64'd7 : 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 64'd1, 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] msg[$];
    logic [15:0] lf;
    logic [15:0] h_a;
    logic [31:0] h_b;
    string digits;
    digits = "123456789";
    repeat (3) @(negedge clk);
    check("R8 reset done", {61'd0, done_a, done_b, done_c}, 64'd0);
    check("R9 reset err", {61'd0, err_a, err_b, err_c}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    msg = {};
    for (int i = 0; i < 9; i++) msg.push_back({8'hA0 + 8'(i), digits[i]});
    send("R2 R11 check string", msg, 0, 1'b0, 1'b0);
    @(negedge clk);
    check("R1 known value", {48'd0, out_a}, 64'hFEE8);
    check("R2 R4 R6 R7 known value", {32'd0, out_b}, 64'hCBF43926);
    h_a = out_a; h_b = out_b;
    repeat (4) @(negedge clk);
    check("R8 result held", {32'd0, out_b}, {32'd0, h_b});
    check("R8 result held a", {48'd0, out_a}, {48'd0, h_a});
    check("R8 done held", {63'd0, done_a}, 64'd1);

    @(negedge clk); sop = 1'b1;
    @(negedge clk); sop = 1'b0;
    send("R3 gaps", msg, 3, 1'b0, 1'b0);
    @(negedge clk);
    check("R3 gaps same value", {48'd0, out_a}, 64'hFEE8);
    send("R9 match", msg, 1, 1'b1, 1'b0);
    send("R9 mismatch", msg, 0, 1'b1, 1'b1);
    send("R10 gen ignores rx", msg, 0, 1'b0, 1'b1);

    msg = {16'h00FF};
    send("R8 single word", msg, 0, 1'b1, 1'b1);
    msg = {16'h0000};
    send("R8 single zero", msg, 0, 1'b0, 1'b0);

    lf = 16'hACE1;
    for (int m = 0; m < 40; m++) begin
      msg = {};
      for (int k = 0; k <= m % 12; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        msg.push_back(lf ^ 16'(m * 37));
      end
      send("R1 R3 R9 R10 random", msg, m % 3, m[0], m[1]);
    end

    repeat (3) @(negedge clk);
    check("R8 scoreboard drained", 64'(sb.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule